// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Resolver

The resolver collects one non-maskable request and twelve maskable request lines into sticky pending bits. On every cycle it chooses a single winner among them. It presents the winner's vector number and byte offset into the vector table, together with a flag that says whether the winner may start a data-transfer activation. A software-visible set of three 16-bit priority registers holds a 3-bit level for each maskable source.

A mode input selects the arbitration scheme. In fixed mode the lowest vector number wins. In programmable mode the highest programmed level wins, and only sources whose level is above the CPU mask level take part. The CPU acknowledges the presented vector with a one-cycle pulse, which retires that source. Any other pending sources are arbitrated again.

Top module: `irq_vec_resolver`

## Requirements
- R1: After reset `vld_o`, `vec_num_o`, `vec_off_o` and `xfer_o` are 0, every pending bit is clear, and every priority field holds level 7, so each of the three priority registers reads 0x7777.
- R2: A request that is high at clock edge n becomes pending at edge n. The outputs show its effect after edge n+1. A change of `mode_i`, `mask_i` or a priority field shows at the outputs after the next edge. `vld_o` is 0 whenever no pending source qualifies.
- R3: With `mode_i` = 0 (fixed), the pending maskable source with the lowest vector number wins. Priority levels and `mask_i` have no effect in this mode.
- R4: The non-maskable source presents vector 7 with offset 0x001C. It wins over every maskable source in both modes, for any `mask_i`. `xfer_o` is 0 while it is presented.
- R5: Maskable line k (0..11) uses vector number 64+k. The offset is always 4 times the vector number, so vector 64 gives 0x100 and vector 75 gives 0x12C.
- R6: With `mode_i` = 1 (programmable), a maskable source qualifies only when its level is strictly greater than `mask_i`. The highest qualifying level wins. A level of 0 never qualifies.
- R7: In programmable mode, among qualifying sources that share the highest level, the lowest vector number wins.
- R8: Register addresses 0, 1 and 2 hold the levels of lines 0-3, 4-7 and 8-11. Line 4a+s sits at bits [14-4s:12-4s] of register a. Bits 15, 11, 7 and 3 read 0 and ignore writes. Address 3 reads 0 and ignores writes.
- R9: `xfer_o` is 1 exactly when `vld_o` is 1 and the presented source is a maskable line whose bit in parameter `XFER_CAP` is set. By default all twelve bits are set.
- R10: An `ack_i` pulse while `vld_o` is 1 clears the pending bit of the presented source. The next winner is presented after the second edge following the pulse. An `ack_i` while `vld_o` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, sets its pending bit |
| irq_i | input | 12 | Maskable request lines, each sets its pending bit |
| ack_i | input | 1 | Retires the presented source |
| mode_i | input | 1 | 0 fixed order, 1 programmable levels |
| mask_i | input | 3 | CPU mask level |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | 2 | Priority register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| vld_o | output | 1 | A vector is presented |
| vec_num_o | output | 8 | Presented vector number |
| vec_off_o | output | 10 | Presented vector table offset |
| xfer_o | output | 1 | Presented source may start a data transfer |

## Verification
The bench targets ties at equal programmed level. A resolver that let the later line win would present 71 instead of 69. It checks a mask equal to the highest level, where a non-strict comparison would raise `vld_o`, and a level of 0, which must stay silent in programmable mode yet win in fixed mode. Single-field writes check the packed field positions, since a wrongly placed slice would promote the wrong line. Acknowledge sequences confirm that only the presented source is retired and that the non-maskable source is never outranked or masked.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_LEVEL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int N_IRQ  = 12,
  parameter int LVL_W  = 3,
  parameter int REG_W  = 16,
  parameter int FPR    = 4,
  parameter int ADDR_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic [N_IRQ*LVL_W-1:0] lvl_o
);
  localparam int STRIDE = REG_W / FPR;

  logic [LVL_W-1:0] lvl_q [N_IRQ];
  logic [REG_W-1:0] used_m;
  logic             unused_wbits;

  always_comb begin
    used_m = '0;
    for (int s = 0; s < FPR; s++) used_m[s*STRIDE +: LVL_W] = '1;
  end
  assign unused_wbits = ^(wdata_i & ~used_m);

  for (genvar k = 0; k < N_IRQ; k++) begin : g_fld
    localparam int RI  = k / FPR;
    localparam int LSB = (FPR - 1 - (k % FPR)) * STRIDE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lvl_q[k] <= '1;
      else if (we_i && (int'(addr_i) == RI))
        lvl_q[k] <= wdata_i[LSB +: LVL_W];
    end
    assign lvl_o[k*LVL_W +: LVL_W] = lvl_q[k];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_IRQ; k++)
      if (int'(addr_i) == k / FPR)
        rdata_o[(FPR-1-(k%FPR))*STRIDE +: LVL_W] = lvl_q[k];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int N_IRQ        = 12,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int NMI_VEC      = 7,
  parameter int IRQ_VEC_BASE = 64,
  localparam int IDX_W       = $clog2(N_IRQ)
) (
  input  logic                   nmi_pend_i,
  input  logic [N_IRQ-1:0]       irq_pend_i,
  input  logic [N_IRQ*LVL_W-1:0] lvl_i,
  input  arb_mode_e              mode_i,
  input  logic [LVL_W-1:0]       mask_i,
  output logic                   hit_o,
  output logic                   is_irq_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best     = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (mode_i == ARB_FIXED) begin
        if (irq_pend_i[i] && !found) begin
          found = 1'b1;
          best  = IDX_W'(i);
        end
      end else if (irq_pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] > mask_i) &&
                   (!found || (lvl_i[i*LVL_W +: LVL_W] > best_lvl))) begin
        // strict compare keeps the lower vector on ties
        found    = 1'b1;
        best     = IDX_W'(i);
        best_lvl = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  assign hit_o    = nmi_pend_i | found;
  assign is_irq_o = !nmi_pend_i && found;
  assign idx_o    = best;
  assign vec_o    = nmi_pend_i ? VEC_W'(NMI_VEC) : VEC_W'(IRQ_VEC_BASE) + VEC_W'(best);
endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver
  import irq_vec_pkg::*;
#(
  parameter int N_IRQ        = 12,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int REG_W        = 16,
  parameter int FPR          = 4,
  parameter int ADDR_W       = 2,
  parameter int NMI_VEC      = 7,
  parameter int IRQ_VEC_BASE = 64,
  parameter logic [N_IRQ-1:0] XFER_CAP = '1,
  localparam int OFF_W       = VEC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              ack_i,
  input  logic              mode_i,
  input  logic [LVL_W-1:0]  mask_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              vld_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [OFF_W-1:0]  vec_off_o,
  output logic              xfer_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic                   nmi_pend_q;
  logic [N_IRQ-1:0]       irq_pend_q;
  logic [N_IRQ*LVL_W-1:0] lvl;
  logic                   hit, is_irq;
  logic [IDX_W-1:0]       idx;
  logic [VEC_W-1:0]       vec;
  logic                   vld_q, xfer_q;
  logic [VEC_W-1:0]       vec_q;
  logic                   retire;

  assign retire = ack_i && vld_q;

  irq_prio_regs #(
    .N_IRQ(N_IRQ), .LVL_W(LVL_W), .REG_W(REG_W), .FPR(FPR), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .lvl_o  (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      nmi_pend_q <= 1'b0;
    else if (nmi_i)
      nmi_pend_q <= 1'b1;
    else if (retire && vec_q == VEC_W'(NMI_VEC))
      nmi_pend_q <= 1'b0;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        irq_pend_q[i] <= 1'b0;
      else if (irq_i[i])
        irq_pend_q[i] <= 1'b1;
      else if (retire && vec_q == VEC_W'(IRQ_VEC_BASE + i))
        irq_pend_q[i] <= 1'b0;
    end
  end

  irq_arbiter #(
    .N_IRQ(N_IRQ), .LVL_W(LVL_W), .VEC_W(VEC_W),
    .NMI_VEC(NMI_VEC), .IRQ_VEC_BASE(IRQ_VEC_BASE)
  ) u_arb (
    .nmi_pend_i(nmi_pend_q),
    .irq_pend_i(irq_pend_q),
    .lvl_i     (lvl),
    .mode_i    (arb_mode_e'(mode_i)),
    .mask_i    (mask_i),
    .hit_o     (hit),
    .is_irq_o  (is_irq),
    .idx_o     (idx),
    .vec_o     (vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      xfer_q <= 1'b0;
    end else begin
      vld_q  <= hit;
      vec_q  <= hit ? vec : '0;
      xfer_q <= is_irq && XFER_CAP[idx];
    end
  end

  assign vld_o     = vld_q;
  assign vec_num_o = vec_q;
  assign vec_off_o = {vec_q, 2'b00};
  assign xfer_o    = xfer_q;
endmodule

// File: rtl/irq_vec_resolver_chk.sv
module irq_vec_resolver_chk #(
  parameter int N_IRQ        = 12,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int REG_W        = 16,
  parameter int FPR          = 4,
  parameter int NMI_VEC      = 7,
  parameter int IRQ_VEC_BASE = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nmi_pend,
  input logic [N_IRQ-1:0] irq_pend,
  input logic             mode_i,
  input logic [LVL_W-1:0] mask_i,
  input logic             vld_o,
  input logic [VEC_W-1:0] vec_num_o,
  input logic             xfer_o,
  input logic [REG_W-1:0] reg_rdata_o
);
  localparam int STRIDE = REG_W / FPR;
  logic [REG_W-1:0] used_m;
  always_comb begin
    used_m = '0;
    for (int s = 0; s < FPR; s++) used_m[s*STRIDE +: LVL_W] = '1;
  end

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!nmi_pend && irq_pend == '0) |-> !vld_o);

  p_nmi_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(nmi_pend) |-> (vld_o && vec_num_o == VEC_W'(NMI_VEC)));

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (vec_num_o == VEC_W'(NMI_VEC) ||
               (vec_num_o >= VEC_W'(IRQ_VEC_BASE) &&
                vec_num_o <  VEC_W'(IRQ_VEC_BASE + N_IRQ))));

  p_mask_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i && mask_i == '1 && !nmi_pend) |-> !vld_o);

  p_unused_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~used_m) == '0);

  p_xfer_irq_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (vld_o && vec_num_o != VEC_W'(NMI_VEC)));
endmodule

bind irq_vec_resolver irq_vec_resolver_chk #(
  .N_IRQ(N_IRQ), .LVL_W(LVL_W), .VEC_W(VEC_W), .REG_W(REG_W), .FPR(FPR),
  .NMI_VEC(NMI_VEC), .IRQ_VEC_BASE(IRQ_VEC_BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nmi_pend   (nmi_pend_q),
  .irq_pend   (irq_pend_q),
  .mode_i     (mode_i),
  .mask_i     (mask_i),
  .vld_o      (vld_o),
  .vec_num_o  (vec_num_o),
  .xfer_o     (xfer_o),
  .reg_rdata_o(reg_rdata_o)
);

// File: tb/sim_irq_vec_resolver.sv
`timescale 1ns/1ps
module sim_irq_vec_resolver;
  localparam int HALF = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nmi_i = 1'b0;
  logic [11:0] irq_i = '0;
  logic        ack_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [2:0]  mask_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        vld_o;
  logic [7:0]  vec_num_o;
  logic [9:0]  vec_off_o;
  logic        xfer_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #HALF clk_i = ~clk_i;

  irq_vec_resolver u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .irq_i(irq_i), .ack_i(ack_i),
    .mode_i(mode_i), .mask_i(mask_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .vld_o(vld_o),
    .vec_num_o(vec_num_o), .vec_off_o(vec_off_o), .xfer_o(xfer_o)
  );

  typedef struct {
    bit    is_reg;
    bit    vld;
    int    num;
    bit    xf;
    int    rd;
    string tag;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;

  // monitor: pops expected items and compares against the ports
  always @(sample_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.is_reg) begin
        if (int'(reg_rdata_o) != it.rd) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata_o, it.rd[15:0]);
        end
      end else if (vld_o != it.vld || (it.vld && (int'(vec_num_o) != it.num ||
                   int'(vec_off_o) != it.num * 4 || xfer_o != it.xf)) ||
                   (!it.vld && xfer_o)) begin
        n_fail++;
        $display("FAIL %s actual vld=%0b vec=%0d off=%h xfer=%0b expected vld=%0b vec=%0d off=%h xfer=%0b",
                 it.tag, vld_o, vec_num_o, vec_off_o, xfer_o, it.vld, it.num, it.num * 4, it.xf);
      end
    end
  end

  task automatic exp_out(bit v, int num, bit xf, string tag);
    item_t it;
    it.is_reg = 1'b0; it.vld = v; it.num = num; it.xf = xf; it.rd = 0; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic exp_reg(logic [1:0] a, int val, string tag);
    item_t it;
    reg_addr_i = a;
    #1;
    it.is_reg = 1'b1; it.vld = 1'b0; it.num = 0; it.xf = 1'b0; it.rd = val; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic pulse(bit nmi, logic [11:0] lines);
    @(negedge clk_i); nmi_i = nmi; irq_i = lines;
    @(negedge clk_i); nmi_i = 1'b0; irq_i = '0;
    @(negedge clk_i);
  endtask

  task automatic ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic drain();
    @(negedge clk_i); mode_i = 1'b0;
    @(negedge clk_i);
    for (int i = 0; i < 20 && vld_o; i++) ack();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_out(0, 0, 0, "R1 reset outputs");
    exp_reg(2'd0, 'h7777, "R1 reset levels reg0");
    exp_reg(2'd2, 'h7777, "R1 reset levels reg2");

    // fixed mode ordering
    pulse(0, 12'h024);
    exp_out(1, 66, 1, "R3 R5 R9 fixed lowest wins");
    ack();
    exp_out(1, 69, 1, "R10 next after ack");
    ack();
    exp_out(0, 0, 0, "R2 R10 nothing left");
    ack();
    exp_out(0, 0, 0, "R10 ack when idle");

    // non-maskable
    pulse(1, 12'h200);
    exp_out(1, 7, 0, "R4 nmi over irq9");
    ack();
    exp_out(1, 73, 1, "R10 irq9 after nmi");
    drain();

    // register layout
    wr(2'd0, 16'hFFFF);
    exp_reg(2'd0, 'h7777, "R8 unused bits ignored");
    wr(2'd0, 16'h1234);
    exp_reg(2'd0, 'h1234, "R8 field readback");
    wr(2'd3, 16'hFFFF);
    exp_reg(2'd3, 0, "R8 addr3 reads zero");
    exp_reg(2'd1, 'h7777, "R8 addr3 write no effect");

    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd0;
    pulse(0, 12'h00F);
    exp_out(1, 67, 1, "R6 highest level wins");
    @(negedge clk_i); mode_i = 1'b0;
    settle();
    exp_out(1, 64, 1, "R3 fixed ignores levels");
    drain();

    // tie at equal level
    wr(2'd1, 16'h5555);
    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd0;
    pulse(0, 12'h0A0);
    exp_out(1, 69, 1, "R7 tie lower vector");
    ack();
    exp_out(1, 71, 1, "R7 R10 remaining tie member");
    drain();

    // mask compare
    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd5;
    pulse(0, 12'h028);
    exp_out(0, 0, 0, "R6 level equal mask blocked");
    @(negedge clk_i); mask_i = 3'd4;
    settle();
    exp_out(1, 69, 1, "R6 R2 mask lowered");
    @(negedge clk_i); mask_i = 3'd3;
    settle();
    ack();
    exp_out(1, 67, 1, "R6 level4 above mask3");
    drain();
    mask_i = 3'd0;

    // level zero
    wr(2'd2, 16'h0000);
    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd0;
    pulse(0, 12'h100);
    exp_out(0, 0, 0, "R6 level zero silent");
    @(negedge clk_i); mode_i = 1'b0; mask_i = 3'd7;
    settle();
    exp_out(1, 72, 1, "R3 fixed ignores mask and level");
    drain();

    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd7;
    pulse(1, 12'h001);
    exp_out(1, 7, 0, "R4 nmi ignores mask");
    drain();
    mask_i = 3'd0;

    pulse(0, 12'h800);
    exp_out(1, 75, 1, "R5 last line offset");
    drain();

    // single field position in reg2
    wr(2'd2, 16'h0030);
    exp_reg(2'd2, 'h0030, "R8 slot2 readback");
    @(negedge clk_i); mode_i = 1'b1; mask_i = 3'd0;
    pulse(0, 12'hF00);
    exp_out(1, 74, 1, "R8 slot2 maps to line10");
    drain();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule